// File: doc/BRIEF.md
# UART Channel FIFO Control

This block holds the two byte queues of one serial channel: a receive queue filled by the receive shifter and drained by the host side, and a transmit queue filled by the host side and drained by the transmit shifter. A control register, written through a simple write strobe, enables the queues, triggers one-shot flushes and selects the trigger thresholds. The block reports both fill levels and two threshold flags that the surrounding logic uses to decide when to service the channel.

The control byte is laid out as follows. Bit 0 is the queue enable. Bit 1 flushes the receive queue. Bit 2 flushes the transmit queue. Bit 3 is a stored mode bit with no function. Bits 5:4 select the transmit threshold. Bits 7:6 select the receive threshold. A separate two-bit input picks which threshold table maps these fields to levels. While the enable is 0, each direction holds at most one byte. Any write that changes the enable bit empties both queues.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, both levels are 0, both empty flags are 1, `rx_trig` is 0 and `tx_trig` is 1.
- R2: A write with bit 0 = 1 stores bits 7:3 and sets the enable. A write with bit 0 = 0 clears the enable and leaves bits 7:3 unchanged. The stored value reads back on the next cycle as `{bits7:3, 2'b00, enable}`.
- R3: A write with bits 0 and 2 both set brings `tx_level` to 0 on the next cycle and leaves `rx_level` unchanged. Bit 2 always reads back as 0.
- R4: A write with bits 0 and 1 both set brings `rx_level` to 0 on the next cycle and leaves `tx_level` unchanged. Bit 1 always reads back as 0.
- R5: Bit 3 is stored and reads back. Setting or clearing it changes neither the levels nor the trigger flags.
- R6: With the enable set, each queue holds up to DEPTH (64) bytes in first-in, first-out order. A push while full and a pop while empty are ignored. The level never exceeds the current capacity.
- R7: With the enable clear, each queue holds at most one byte. It reports full at level 1 and keeps the first byte pushed.
- R8: Any write that changes the enable bit empties both queues by the next cycle. A write that leaves the enable unchanged does not empty them.
- R9: For `tbl_sel` values 00, 10 and 11, control bits 7:6 = 00/01/10/11 give a receive threshold of 1/4/8/14, and the transmit threshold is 1.
- R10: For `tbl_sel` = 01, control bits 7:6 = 00/01/10/11 give a receive threshold of 8/16/24/28.
- R11: For `tbl_sel` = 01, control bits 5:4 = 00/01/10/11 give a transmit threshold of 16/8/24/30.
- R12: `rx_trig` is 1 while `rx_level` is at or above the receive threshold. `tx_trig` is 1 while `tx_level` is at or below the transmit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control register readback |
| tbl_sel | input | 2 | Threshold table select (01 = table B, else table A) |
| rx_push | input | 1 | Receive shifter pushes a byte |
| rx_wdata | input | DW (8) | Received byte |
| rx_pop | input | 1 | Host pops a received byte |
| rx_rdata | output | DW (8) | Oldest received byte |
| tx_push | input | 1 | Host pushes a byte to send |
| tx_wdata | input | DW (8) | Byte to send |
| tx_pop | input | 1 | Transmit shifter pops a byte |
| tx_rdata | output | DW (8) | Oldest byte to send |
| rx_level | output | LW (7) | Receive fill level |
| tx_level | output | LW (7) | Transmit fill level |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_trig | output | 1 | Receive threshold reached |
| tx_trig | output | 1 | Transmit level at or below threshold |

## Verification
The threshold logic is tested with all four values of `tbl_sel` against all four settings of each field. In each case the bench fills the queue to one byte below the threshold and then to the threshold. This separates an off-by-one comparison from a wrong table entry, and shows whether the unused select codes fall back to table A. The queues are tested with a full 64-byte fill and drain using a non-repeating byte pattern, which exposes ordering and wrap faults. The disabled one-byte mode and the flush writes are tested with data already held in both queues. This shows whether a flush, or a gated write, reaches the wrong direction.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [1:0]    tbl_sel,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] tx_level,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          rx_trig,
  output logic          tx_trig
);

  logic       en;
  logic [4:0] hi;

  wire wr_on  = cfg_we & cfg_wdata[0];
  wire en_chg = cfg_we & (cfg_wdata[0] != en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0;
      hi <= '0;
    end else if (cfg_we) begin
      en <= cfg_wdata[0];
      if (cfg_wdata[0]) hi <= cfg_wdata[7:3];
    end

  assign cfg_rdata = {hi, 2'b00, en};

  wire [LW-1:0] cap = en ? LW'(DEPTH) : LW'(1);

  logic [1:0]          push, pop, flush;
  logic [1:0][DW-1:0]  wd, rd;
  logic [1:0][LW-1:0]  lvl;

  assign push  = {tx_push, rx_push};
  assign pop   = {tx_pop, rx_pop};
  assign wd    = {tx_wdata, rx_wdata};
  assign flush = {(wr_on & cfg_wdata[2]) | en_chg, (wr_on & cfg_wdata[1]) | en_chg};

  for (genvar d = 0; d < 2; d++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    wire do_pop  = pop[d] && (cnt != '0);
    wire do_push = push[d] && ((cnt < cap) || do_pop);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (flush[d]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= wp + AW'(1);
        if (do_pop)  rp <= rp + AW'(1);
        if (do_push && !do_pop)      cnt <= cnt + LW'(1);
        else if (do_pop && !do_push) cnt <= cnt - LW'(1);
      end

    always_ff @(posedge clk)
      if (do_push && !flush[d]) mem[wp] <= wd[d];

    assign rd[d]  = mem[rp];
    assign lvl[d] = cnt;
  end

  logic [4:0] rx_thr, tx_thr;
  wire tbl_b = (tbl_sel == 2'b01);

  always_comb begin
    case ({tbl_b, hi[4:3]})
      3'b000:  rx_thr = 5'd1;
      3'b001:  rx_thr = 5'd4;
      3'b010:  rx_thr = 5'd8;
      3'b011:  rx_thr = 5'd14;
      3'b100:  rx_thr = 5'd8;
      3'b101:  rx_thr = 5'd16;
      3'b110:  rx_thr = 5'd24;
      default: rx_thr = 5'd28;
    endcase
    if (!tbl_b) tx_thr = 5'd1;
    else
      case (hi[2:1])
        2'b00:   tx_thr = 5'd16;
        2'b01:   tx_thr = 5'd8;
        2'b10:   tx_thr = 5'd24;
        default: tx_thr = 5'd30;
      endcase
  end

  assign rx_rdata = rd[0];
  assign tx_rdata = rd[1];
  assign rx_level = lvl[0];
  assign tx_level = lvl[1];
  assign rx_empty = (lvl[0] == '0);
  assign tx_empty = (lvl[1] == '0);
  assign rx_full  = (lvl[0] == cap);
  assign tx_full  = (lvl[1] == cap);
  assign rx_trig  = (lvl[0] >= LW'(rx_thr));
  assign tx_trig  = (lvl[1] <= LW'(tx_thr));

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_trig,
  input logic          tx_trig
);

  wire [LW-1:0] lim = cfg_rdata[0] ? LW'(DEPTH) : LW'(1);

  // R6
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= lim) && (tx_level <= lim));

  // R2
  gate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[0]) |=> (cfg_rdata[7:3] == $past(cfg_rdata[7:3])) && !cfg_rdata[0]);

  // R3
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_level == '0));

  // R4
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_level == '0));

  // R4
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2:1] == 2'b00);

  // R8
  en_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[0] != cfg_rdata[0])) |=> (rx_level == '0) && (tx_level == '0));

  // R12
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_trig);

  // R12
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_trig);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .rx_level(rx_level), .tx_level(tx_level),
  .rx_trig(rx_trig), .tx_trig(tx_trig)
);

// File: tb/sim_uart_fifo_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctl;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [1:0] tbl_sel = 0;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
  logic [LW-1:0] rx_level, tx_level;
  logic rx_empty, rx_full, tx_empty, tx_full, rx_trig, tx_trig;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(input int d, input logic [7:0] v);
    if (d == 0) begin rx_push = 1; rx_wdata = v; end
    else begin tx_push = 1; tx_wdata = v; end
    @(negedge clk);
    rx_push = 0; tx_push = 0;
  endtask

  task automatic pop(input int d);
    if (d == 0) rx_pop = 1; else tx_pop = 1;
    @(negedge clk);
    rx_pop = 0; tx_pop = 0;
  endtask

  function automatic int exp_rx(int sel, int k);
    if (sel == 1) case (k) 0: return 8; 1: return 16; 2: return 24; default: return 28; endcase
    case (k) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic int exp_tx(int sel, int k);
    if (sel == 1) case (k) 0: return 16; 1: return 8; 2: return 24; default: return 30; endcase
    return 1;
  endfunction

  task automatic t_reset;
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_trig", rx_trig, 0);
    chk("R1 tx_trig", tx_trig, 1);
  endtask

  task automatic t_disabled;
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
    chk("R7 rx_level", rx_level, 1);
    chk("R7 rx_full", rx_full, 1);
    chk("R7 rx_rdata", rx_rdata, 8'h11);
    push(1, 8'h44);
    chk("R7 tx_level", tx_level, 1);
    wr(8'h00);
    chk("R8 same enable keeps rx", rx_level, 1);
    wr(8'h01);
    chk("R8 enable empties rx", rx_level, 0);
    chk("R8 enable empties tx", tx_level, 0);
    chk("R2 rdata", cfg_rdata, 8'h01);
  endtask

  task automatic t_depth;
    for (int i = 0; i < DEPTH; i++) push(0, 8'(i * 3 + 7));
    chk("R6 level full", rx_level, DEPTH);
    chk("R6 full flag", rx_full, 1);
    push(0, 8'hEE);
    chk("R6 push at full", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 order", rx_rdata, (i * 3 + 7) % 256);
      pop(0);
    end
    chk("R6 drained", rx_level, 0);
    pop(0);
    chk("R6 pop at empty", rx_level, 0);
    chk("R6 empty flag", rx_empty, 1);
  endtask

  task automatic t_gating;
    wr(8'hC9);
    chk("R2 stored", cfg_rdata, 8'hC9);
    push(0, 8'h5A); push(1, 8'hA5);
    wr(8'h30);
    chk("R2 gated", cfg_rdata, 8'hC8);
    chk("R8 disable empties rx", rx_level, 0);
    chk("R8 disable empties tx", tx_level, 0);
    wr(8'h01);
    chk("R2 reenable", cfg_rdata, 8'h01);
  endtask

  task automatic t_flush;
    for (int i = 0; i < 5; i++) push(0, 8'(i));
    for (int i = 0; i < 7; i++) push(1, 8'(i));
    wr(8'h05);
    chk("R3 tx cleared", tx_level, 0);
    chk("R3 rx kept", rx_level, 5);
    chk("R3 bit reads 0", cfg_rdata, 8'h01);
    push(1, 8'h77);
    wr(8'h03);
    chk("R4 rx cleared", rx_level, 0);
    chk("R4 tx kept", tx_level, 1);
    chk("R4 bit reads 0", cfg_rdata, 8'h01);
    wr(8'h07);
  endtask

  task automatic t_mode_bit;
    push(0, 8'h01); push(0, 8'h02); push(0, 8'h03);
    wr(8'h09);
    chk("R5 readback", cfg_rdata, 8'h09);
    chk("R5 level kept", rx_level, 3);
    chk("R5 rx_trig", rx_trig, 1);
    chk("R5 tx_trig", tx_trig, 1);
    wr(8'h01);
    chk("R5 cleared", cfg_rdata, 8'h01);
    chk("R5 level kept", rx_level, 3);
    wr(8'h03);
  endtask

  task automatic t_tables;
    for (int sel = 0; sel < 4; sel++)
      for (int k = 0; k < 4; k++) begin
        string r;
        int th, tt;
        tbl_sel = 2'(sel);
        wr(8'((k << 6) | (k << 4) | 7));
        th = exp_rx(sel, k);
        tt = exp_tx(sel, k);
        r = (sel == 1) ? "R10 R12 rx" : "R9 R12 rx";
        for (int i = 0; i < th - 1; i++) push(0, 8'(i));
        chk(r, rx_trig, 0);
        push(0, 8'hFF);
        chk(r, rx_trig, 1);
        r = (sel == 1) ? "R11 R12 tx" : "R9 R12 tx";
        for (int i = 0; i < tt; i++) push(1, 8'(i));
        chk(r, tx_trig, 1);
        push(1, 8'hFF);
        chk(r, tx_trig, 0);
      end
    tbl_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_depth;
    t_gating;
    t_flush;
    t_mode_bit;
    t_tables;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule